// File: doc/BRIEF.md
# Fractional Clock-Enable Scaler with Committed Ratio

This block produces a clock-enable pulse stream on the parent clock. Its average rate is the parent rate times mult/32, where mult runs from 1 to 32. Software programs the ratio as a 5-bit field that holds 32 minus the multiplier. So a field of 0 selects the full rate and a field of 31 selects one pulse in 32.

Writing the field alone changes nothing at the output. Software must then set a self-clearing kick bit in a second register. The hardware takes a copy of the field at that moment. It applies the copy when the fractional accumulator is back at phase zero, then clears the kick bit. Software polls the kick bit to see when the change is done.

The pulses are spread evenly by a modulo-32 accumulator. Each cycle it adds mult and raises the enable on carry-out.

The commit logic is a two-state machine:
- ST_IDLE has no change pending. The transition "kick" (a write of 1 to the kick bit) moves it to ST_WAIT and takes the copy of the field.
- ST_WAIT holds a pending change. The transition "apply" fires on the first cycle in which the accumulator is at zero. It loads the copy as the active ratio and returns to ST_IDLE.

Top module: `fcs_scaler`

## Requirements
- R1: After reset the ratio field reads 0, the kick bit reads 0, and the enable is high on every cycle.
- R2: The ratio field sits at bits 12:8 of the register at offset 0x0E0. Reading that offset returns the stored field at those bits and 0 in every other bit.
- R3: With an active field F, the multiplier is 32-F. Any 32 consecutive cycles contain exactly 32-F enable pulses.
- R4: Writing the ratio field without a kick leaves the enable rate unchanged.
- R5: The kick bit is bit 31 at offset 0x004. Writing a 1 there while idle makes it read 1 on the next cycle.
- R6: A pending kick clears itself within 33 cycles of the write. The new ratio starts at accumulator phase zero.
- R7: Ratio writes made while a kick is pending are stored and read back. The pending commit still applies the value present at the kick, and the later value takes effect only on the next kick.
- R8: Writing 0 to the kick bit commits nothing: the kick bit stays 0 and the rate is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Parent clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 12 | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| en_o | output | 1 | Clock-enable pulse output |

## Verification
The main function is tested with eight ratio fields:
- Field 0 and field 31 are the two ends of the multiplier range. They confirm that the 32-minus encoding is not off by one at either end.
- Fields 16, 8, 3, 20, 27 and 1 give pulse counts that are even, odd, high and low. A wrong encoding or a dropped carry shows up as a wrong count in a 32-cycle window.

Further patterns separate the commit rules:
- A field written with no kick.
- A kick written as 0.
- A field written while a kick is pending.
- An all-ones write that probes where the field sits.

These show whether the output follows the stored field, the copy taken at the kick, or the active ratio.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } commit_state_e;
endpackage

// File: rtl/fcs_regs.sv
module fcs_regs #(
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 32,
    parameter int FRAC_BITS = 5,
    parameter int FIELD_LSB = 8,
    parameter int KICK_BIT  = 31,
    parameter logic [ADDR_W-1:0] CTRL_OFS = 12'h0E0,
    parameter logic [ADDR_W-1:0] KICK_OFS = 12'h004
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 wr_en_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [DATA_W-1:0]    wdata_i,
    input  logic                 busy_i,
    output logic [DATA_W-1:0]    rdata_o,
    output logic [FRAC_BITS-1:0] field_o,
    output logic                 kick_wr_o
);
    localparam int FIELD_MSB = FIELD_LSB + FRAC_BITS - 1;

    logic                 ctrl_hit;
    logic                 kick_hit;
    logic [FRAC_BITS-1:0] field_q;

    assign ctrl_hit  = (addr_i == CTRL_OFS);
    assign kick_hit  = (addr_i == KICK_OFS);
    assign kick_wr_o = wr_en_i && kick_hit && wdata_i[KICK_BIT];
    assign field_o   = field_q;

    // Stored ratio field; only the field bits are kept.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            field_q <= '0;
        end else if (wr_en_i && ctrl_hit) begin
            field_q <= wdata_i[FIELD_MSB:FIELD_LSB];
        end
    end

    // Read mux; unmapped bits and offsets return zero.
    always_comb begin
        rdata_o = '0;
        if (ctrl_hit) begin
            rdata_o[FIELD_MSB:FIELD_LSB] = field_q;
        end else if (kick_hit) begin
            rdata_o[KICK_BIT] = busy_i;
        end
    end

    // R2: a write to the control offset is stored exactly as written.
    a_r2_field_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && ctrl_hit) |=> (field_q == $past(wdata_i[FIELD_MSB:FIELD_LSB])));
endmodule

// File: rtl/fcs_commit_fsm.sv
module fcs_commit_fsm
    import fcs_pkg::*;
#(
    parameter int FRAC_BITS = 5
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 kick_wr_i,
    input  logic [FRAC_BITS-1:0] field_i,
    input  logic [FRAC_BITS-1:0] acc_i,
    output logic                 busy_o,
    output logic [FRAC_BITS:0]   mult_o
);
    localparam int DEN    = 1 << FRAC_BITS;
    localparam int MULT_W = FRAC_BITS + 1;
    localparam int CNT_W  = MULT_W + 1;

    commit_state_e        state_q, state_d;
    logic [FRAC_BITS-1:0] staged_q;
    logic [FRAC_BITS-1:0] active_q;
    logic [FRAC_BITS-1:0] sel_field;
    logic                 apply;
    logic [CNT_W-1:0]     wait_cnt_q;

    assign apply = (state_q == ST_WAIT) && (acc_i == '0);

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (kick_wr_i) state_d = ST_WAIT;
            ST_WAIT: if (acc_i == '0) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register, plus the copy taken at the kick and the active ratio.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q  <= ST_IDLE;
            staged_q <= '0;
            active_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && kick_wr_i) staged_q <= field_i;
            if (apply) active_q <= staged_q;
        end
    end

    // Outputs.
    always_comb begin
        busy_o    = (state_q == ST_WAIT);
        sel_field = apply ? staged_q : active_q;
        mult_o    = MULT_W'(DEN) - MULT_W'(sel_field);
    end

    // Cycles spent waiting, used only by the bound check below.
    always_ff @(posedge clk_i) begin
        if (!rst_ni || state_q == ST_IDLE) begin
            wait_cnt_q <= '0;
        end else if (wait_cnt_q != '1) begin
            wait_cnt_q <= wait_cnt_q + 1'b1;
        end
    end

    // R5: a kick while idle is seen as busy on the next cycle.
    a_r5_kick_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (kick_wr_i && !busy_o) |=> busy_o);

    // R6: a pending commit never waits longer than one accumulator period.
    a_r6_commit_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wait_cnt_q <= CNT_W'(DEN));

    // R7: while a commit waits away from phase zero, the active ratio holds.
    a_r7_active_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && acc_i != '0) |=> $stable(active_q));

    // R8: without a kick, the machine never leaves idle.
    a_r8_no_kick_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && !kick_wr_i) |=> !busy_o);
endmodule

// File: rtl/fcs_accum.sv
module fcs_accum #(
    parameter int FRAC_BITS = 5
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [FRAC_BITS:0]   mult_i,
    output logic [FRAC_BITS-1:0] acc_o,
    output logic                 en_o
);
    localparam int DEN    = 1 << FRAC_BITS;
    localparam int MULT_W = FRAC_BITS + 1;

    logic [FRAC_BITS-1:0] acc_q;
    logic [MULT_W-1:0]    sum;

    assign sum   = MULT_W'(acc_q) + mult_i;
    assign en_o  = sum[FRAC_BITS];
    assign acc_o = acc_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            acc_q <= '0;
        end else begin
            acc_q <= sum[FRAC_BITS-1:0];
        end
    end

    // R3: after a carry the remainder is below the step.
    a_r3_carry_rem: assert property (@(posedge clk_i) disable iff (!rst_ni)
        en_o |=> (MULT_W'(acc_q) < $past(mult_i)));

    // R3: without a carry the accumulator advanced by the full step.
    a_r3_no_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_o |=> (MULT_W'(acc_q) >= $past(mult_i)));

    // R3: the multiplier stays within 1..32.
    a_r3_mult_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mult_i != '0) && (mult_i <= MULT_W'(DEN)));
endmodule

// File: rtl/fcs_scaler.sv
module fcs_scaler #(
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 32,
    parameter int FRAC_BITS = 5,
    parameter int FIELD_LSB = 8,
    parameter int KICK_BIT  = 31,
    parameter logic [ADDR_W-1:0] CTRL_OFS = 12'h0E0,
    parameter logic [ADDR_W-1:0] KICK_OFS = 12'h004
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              en_o
);
    logic [FRAC_BITS-1:0] field;
    logic                 kick_wr;
    logic                 busy;
    logic [FRAC_BITS-1:0] acc;
    logic [FRAC_BITS:0]   mult;

    fcs_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FRAC_BITS(FRAC_BITS),
        .FIELD_LSB(FIELD_LSB), .KICK_BIT(KICK_BIT),
        .CTRL_OFS(CTRL_OFS), .KICK_OFS(KICK_OFS)
    ) regs_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
        .wdata_i(wdata_i), .busy_i(busy), .rdata_o(rdata_o),
        .field_o(field), .kick_wr_o(kick_wr)
    );

    fcs_commit_fsm #(.FRAC_BITS(FRAC_BITS)) fsm_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .kick_wr_i(kick_wr), .field_i(field),
        .acc_i(acc), .busy_o(busy), .mult_o(mult)
    );

    fcs_accum #(.FRAC_BITS(FRAC_BITS)) accum_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .mult_i(mult), .acc_o(acc), .en_o(en_o)
    );
endmodule

// File: tb/fcs_scaler_tb_top.sv
module fcs_scaler_tb_top;
    localparam logic [11:0] CTRL = 12'h0E0;
    localparam logic [11:0] KICK = 12'h004;
    localparam int NVEC = 8;
    localparam logic [4:0] VFIELD [NVEC] = '{5'd0, 5'd1, 5'd31, 5'd16, 5'd8, 5'd27, 5'd3, 5'd20};
    localparam int         VEXP   [NVEC] = '{32,   31,   1,     16,    24,   5,     29,   12};

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [11:0] addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic        en;
    int          checks = 0;
    int          errors = 0;
    bit          done = 0;

    always #10 clk = ~clk;

    fcs_scaler dut_i (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
        .wdata_i(wdata), .rdata_o(rdata), .en_o(en)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic count_en(output int c);
        c = 0;
        repeat (32) begin
            @(negedge clk);
            if (en) c++;
        end
    endtask

    task automatic poll_clear(input string tag);
        logic [31:0] d;
        int polls;
        polls = 0;
        rd(KICK, d);
        while (d[31] && polls < 1000) begin
            @(negedge clk);
            polls++;
            rd(KICK, d);
        end
        if (d[31]) begin
            checks++; errors++;
            $display("FAIL %s kick still set actual=%0d polls expected=<1000", tag, polls);
        end else begin
            chk({tag, " R6 polls<=33"}, 32'(polls <= 33), 32'd1);
        end
    endtask

    task automatic kick_wait(input string tag);
        wr(KICK, 32'h8000_0000);
        poll_clear(tag);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int c;
        rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
        do_reset();

        // R1: reset state
        rd(CTRL, d); chk("R1 ctrl after reset", d, 32'h0);
        rd(KICK, d); chk("R1 kick after reset", d, 32'h0);
        count_en(c); chk("R1 full rate after reset", 32'(c), 32'd32);

        // R3 / R2 / R6: vector table
        for (int i = 0; i < NVEC; i++) begin
            wr(CTRL, 32'(VFIELD[i]) << 8);
            kick_wait("R6 vector");
            count_en(c); chk("R3 vector count", 32'(c), 32'(VEXP[i]));
            rd(CTRL, d); chk("R2 vector readback", d, 32'(VFIELD[i]) << 8);
        end

        // R4: field write without kick keeps rate (mult 12)
        wr(CTRL, 32'd5 << 8);
        count_en(c); chk("R4 no kick keeps rate", 32'(c), 32'd12);

        // R8: writing kick as 0 commits nothing
        wr(KICK, 32'h0);
        rd(KICK, d); chk("R8 kick reads 0", d, 32'h0);
        count_en(c); chk("R8 rate unchanged", 32'(c), 32'd12);
        kick_wait("R5 kick commits");
        count_en(c); chk("R5 commit after kick", 32'(c), 32'd27);

        // R2: only bits 12:8 are stored
        wr(CTRL, 32'hFFFF_FFFF);
        rd(CTRL, d); chk("R2 field position", d, 32'h0000_1F00);
        kick_wait("R6 all-ones");
        count_en(c); chk("R3 field 31 gives one pulse", 32'(c), 32'd1);

        // R7: write during a pending kick
        wr(CTRL, 32'd10 << 8);
        wr(KICK, 32'h8000_0000);
        wr(CTRL, 32'd2 << 8);
        poll_clear("R7 pending");
        count_en(c); chk("R7 commit uses kicked value", 32'(c), 32'd22);
        rd(CTRL, d); chk("R7 later write stored", d, 32'd2 << 8);
        kick_wait("R7 second kick");
        count_en(c); chk("R7 later value on next kick", 32'(c), 32'd30);

        // R1: reset during operation
        do_reset();
        rd(CTRL, d); chk("R1 ctrl after re-reset", d, 32'h0);
        count_en(c); chk("R1 full rate after re-reset", 32'(c), 32'd32);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule